// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider

This block is the feedback divider of a frequency synthesizer loop. It counts cycles of a fast input clock and gives one output pulse every N cycles, where N = B·P + A. A dual-modulus prescaler divides the input clock by P or by P+1. Two counters steer it: a swallow counter A and a main counter B. In each output period, the first A prescaler cycles run at P+1 and the remaining B−A cycles run at P. The extra counts that the A counter "swallows" make up the fine step of the ratio. The prescaler is a synthesizable down-counter here, not an analog circuit.

Software-side logic writes the counters through a small configuration port. A one-cycle load strobe captures A, B and a 2-bit prescaler select into a pending register. The running divider takes these values only when its current output period ends, so no period is ever cut short. A pending setting that cannot be divided as requested (A larger than B, or B of zero) is corrected before use, and a flag reports it.

Top module: `pswallow_div`

## Requirements
- R1: While `rst_n` is low, `div_pulse`, `mod_ctrl` and `cfg_invalid` are 0. The reset configuration is A=0, B=1, P=8, so the first period after reset is 8 cycles long.
- R2: `div_pulse` is high for exactly one input cycle at the end of each period. Consecutive pulses are exactly N = B·P + A cycles apart.
- R3: `mod_ctrl` (1 = divide by P+1, 0 = divide by P) is high for the first A·(P+1) cycles of each period and low for the other cycles.
- R4: `cfg_psel` picks the prescaler modulus P = 8 << code, so code 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 64.
- R5: A `cfg_load` strobe changes nothing in the period under way. The loaded values apply from the first cycle after the next `div_pulse`.
- R6: When the loaded A exceeds B, `cfg_invalid` rises on the cycle after the load and A is used as equal to B, so N = B·(P+1).
- R7: A loaded B of 0 is used as B = 1, with A clamped to at most 1, and it sets `cfg_invalid`.
- R8: `cfg_invalid` describes the most recent load only. A valid load clears it on the following cycle.
- R9: When several loads fall inside one period, only the last one is applied at the boundary.
- R10: With A = 0, `mod_ctrl` stays low for the whole period and N = B·P.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-rate input clock being divided |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | One-cycle strobe that captures the three configuration fields |
| cfg_a | input | 5 | Swallow count A |
| cfg_b | input | 13 | Main count B |
| cfg_psel | input | 2 | Prescaler modulus select, P = 8 << code |
| div_pulse | output | 1 | One-cycle pulse at the end of each N-cycle period |
| mod_ctrl | output | 1 | Modulus control, 1 while the prescaler divides by P+1 |
| cfg_invalid | output | 1 | The last loaded setting had to be corrected |

## Verification
The assertions assume that the configuration inputs are sampled only when `cfg_load` is high. They also assume that the reset defaults are a legal setting, so every period is at least eight cycles long and a pulse can never follow another pulse directly. The stimulus changes the inputs only on the falling clock edge and holds `cfg_load` high for single cycles. It keeps A and B small enough that each period ends within a few thousand cycles. The settings that break the rules (A above B, and B of zero) are sent through the normal load path, so the clamping logic is what keeps the counters in their legal range.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

   // Counter width needed to hold (largest modulus + 1) - 1
   function automatic int unsigned pre_cnt_width(input int unsigned log2_min,
                                                 input int unsigned sel_w);
      return log2_min + (1 << sel_w);
   endfunction

   // Reload value of the prescaler counter for a given select and modulus choice
   function automatic int unsigned pre_reload(input int unsigned log2_min,
                                              input int unsigned sel,
                                              input bit          plus_one);
      return (1 << (log2_min + sel)) - 1 + (plus_one ? 1 : 0);
   endfunction

endpackage

// File: rtl/pswallow_cfg_latch.sv
module pswallow_cfg_latch #(
   parameter int unsigned A_W   = 5,
   parameter int unsigned B_W   = 13,
   parameter int unsigned S_W   = 2,
   parameter int unsigned RST_A = 0,
   parameter int unsigned RST_B = 1,
   parameter int unsigned RST_S = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic [A_W-1:0] a_in,
   input  logic [B_W-1:0] b_in,
   input  logic [S_W-1:0] s_in,
   output logic [A_W-1:0] pend_a,
   output logic [B_W-1:0] pend_b,
   output logic [S_W-1:0] pend_s,
   output logic           invalid
);

   logic [B_W-1:0] a_wide;
   logic [B_W-1:0] b_fix;
   logic           b_zero;
   logic           a_over;
   logic [A_W-1:0] a_fix;

   initial begin
      assert (A_W <= B_W) else $error("swallow counter wider than main counter");
      assert (RST_B >= 1 && RST_A <= RST_B) else $error("reset setting is not legal");
   end

   always_comb begin
      a_wide = B_W'(a_in);
      b_zero = (b_in == '0);
      b_fix  = b_zero ? B_W'(1) : b_in;
      a_over = (a_wide > b_fix);
      a_fix  = a_over ? b_fix[A_W-1:0] : a_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_a  <= A_W'(RST_A);
         pend_b  <= B_W'(RST_B);
         pend_s  <= S_W'(RST_S);
         invalid <= 1'b0;
      end else if (load) begin
         pend_a  <= a_fix;
         pend_b  <= b_fix;
         pend_s  <= s_in;
         invalid <= b_zero || (a_wide > b_in);
      end
   end

   // R6: a load with A above B raises the flag and leaves A no larger than B
   a_r6_flag_over: assert property (@(posedge clk) disable iff (!rst_n)
      load && (B_W'(a_in) > b_in) |=> invalid && (B_W'(pend_a) == pend_b));

   // R7: a zero B is stored as one and flagged
   a_r7_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
      load && (b_in == '0) |=> invalid && (pend_b == B_W'(1)));

   // R8: a legal load clears the flag
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      load && (b_in != '0) && (B_W'(a_in) <= b_in) |=> !invalid);

endmodule

// File: rtl/pswallow_prescaler.sv
module pswallow_prescaler #(
   parameter int unsigned S_W      = 2,
   parameter int unsigned LOG2_MIN = 3,
   parameter int unsigned RST_CNT  = 7,
   localparam int unsigned C_W     = pswallow_pkg::pre_cnt_width(LOG2_MIN, S_W)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [S_W-1:0] nxt_sel,
   input  logic           nxt_plus1,
   output logic           tc
);

   logic [C_W-1:0] cnt;
   logic [C_W-1:0] base;
   logic [C_W-1:0] reload;

   initial begin
      assert (LOG2_MIN >= 2) else $error("smallest modulus must be at least 4");
      assert (RST_CNT < (1 << C_W)) else $error("reset count does not fit");
   end

   generate
      if (S_W == 0) begin : g_fixed
         assign base = C_W'(1) << LOG2_MIN;
      end else begin : g_select
         assign base = C_W'(1) << (C_W'(LOG2_MIN) + C_W'(nxt_sel));
      end
   endgenerate

   assign reload = base - C_W'(1) + C_W'(nxt_plus1);
   assign tc     = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)  cnt <= C_W'(RST_CNT);
      else if (tc) cnt <= reload;
      else         cnt <= cnt - C_W'(1);
   end

   // R4: every prescaler cycle lasts at least the smallest modulus
   a_r4_reload_min: assert property (@(posedge clk) disable iff (!rst_n)
      tc |=> (cnt >= C_W'((1 << LOG2_MIN) - 1)));

endmodule

// File: rtl/pswallow_swallow.sv
module pswallow_swallow #(
   parameter int unsigned A_W   = 5,
   parameter int unsigned B_W   = 13,
   parameter int unsigned S_W   = 2,
   parameter int unsigned RST_A = 0,
   parameter int unsigned RST_B = 1,
   parameter int unsigned RST_S = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           pre_tc,
   input  logic [A_W-1:0] pend_a,
   input  logic [B_W-1:0] pend_b,
   input  logic [S_W-1:0] pend_s,
   output logic           mod_ctrl,
   output logic           period_end,
   output logic           nxt_plus1,
   output logic [S_W-1:0] nxt_sel
);

   logic [A_W-1:0] a_rem;
   logic [B_W-1:0] b_rem;
   logic [S_W-1:0] act_s;
   logic [A_W-1:0] a_after;

   assign period_end = pre_tc && (b_rem == B_W'(1));
   assign mod_ctrl   = (a_rem != '0);

   always_comb begin
      if (period_end)      a_after = pend_a;
      else if (a_rem != '0) a_after = a_rem - A_W'(1);
      else                 a_after = '0;
      nxt_plus1 = (a_after != '0);
      nxt_sel   = period_end ? pend_s : act_s;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_rem <= A_W'(RST_A);
         b_rem <= B_W'(RST_B);
         act_s <= S_W'(RST_S);
      end else if (pre_tc) begin
         a_rem <= a_after;
         b_rem <= period_end ? pend_b : (b_rem - B_W'(1));
         if (period_end) act_s <= pend_s;
      end
   end

   // R2: the main counter never runs dry inside a period
   a_r2_b_live: assert property (@(posedge clk) disable iff (!rst_n)
      b_rem != '0);

   // R6: swallow cycles left never exceed prescaler cycles left
   a_r6_a_le_b: assert property (@(posedge clk) disable iff (!rst_n)
      B_W'(a_rem) <= b_rem);

   // R5: the active prescaler select moves only at a period boundary
   a_r5_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !period_end |=> $stable(act_s));

endmodule

// File: rtl/pswallow_div.sv
module pswallow_div #(
   parameter int unsigned A_W      = 5,
   parameter int unsigned B_W      = 13,
   parameter int unsigned S_W      = 2,
   parameter int unsigned LOG2_MIN = 3,
   parameter int unsigned RST_A    = 0,
   parameter int unsigned RST_B    = 1,
   parameter int unsigned RST_S    = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_load,
   input  logic [A_W-1:0] cfg_a,
   input  logic [B_W-1:0] cfg_b,
   input  logic [S_W-1:0] cfg_psel,
   output logic           div_pulse,
   output logic           mod_ctrl,
   output logic           cfg_invalid
);

   localparam int unsigned RST_CNT =
      pswallow_pkg::pre_reload(LOG2_MIN, RST_S, RST_A != 0);

   logic [A_W-1:0] pend_a;
   logic [B_W-1:0] pend_b;
   logic [S_W-1:0] pend_s;
   logic           pre_tc;
   logic           period_end;
   logic           nxt_plus1;
   logic [S_W-1:0] nxt_sel;

   pswallow_cfg_latch #(
      .A_W(A_W), .B_W(B_W), .S_W(S_W),
      .RST_A(RST_A), .RST_B(RST_B), .RST_S(RST_S)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .load(cfg_load),
      .a_in(cfg_a), .b_in(cfg_b), .s_in(cfg_psel),
      .pend_a(pend_a), .pend_b(pend_b), .pend_s(pend_s),
      .invalid(cfg_invalid)
   );

   pswallow_prescaler #(
      .S_W(S_W), .LOG2_MIN(LOG2_MIN), .RST_CNT(RST_CNT)
   ) u_pre (
      .clk(clk), .rst_n(rst_n),
      .nxt_sel(nxt_sel), .nxt_plus1(nxt_plus1),
      .tc(pre_tc)
   );

   pswallow_swallow #(
      .A_W(A_W), .B_W(B_W), .S_W(S_W),
      .RST_A(RST_A), .RST_B(RST_B), .RST_S(RST_S)
   ) u_swl (
      .clk(clk), .rst_n(rst_n), .pre_tc(pre_tc),
      .pend_a(pend_a), .pend_b(pend_b), .pend_s(pend_s),
      .mod_ctrl(mod_ctrl), .period_end(period_end),
      .nxt_plus1(nxt_plus1), .nxt_sel(nxt_sel)
   );

   assign div_pulse = period_end;

   // R2: the output pulse is one cycle wide
   a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> !div_pulse);

   // R3: the P+1 phase can only begin right after a period boundary
   a_r3_mod_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mod_ctrl) |-> $past(div_pulse));

   // R1: outputs are quiet while reset is held
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!rst_n) -> (!div_pulse && !cfg_invalid));

endmodule

// File: tb/pswallow_div_bench.sv
module pswallow_div_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_load = 1'b0;
   logic [4:0]  cfg_a = '0;
   logic [12:0] cfg_b = '0;
   logic [1:0]  cfg_psel = '0;
   logic        div_pulse, mod_ctrl, cfg_invalid;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // behavioural reference state
   int k = 0;
   int act_a = 0, act_b = 1, act_p = 8;
   int pend_a = 0, pend_b = 1, pend_p = 8;
   bit pend_inv = 1'b0;

   pswallow_div u_pswallow_div (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
      .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg_psel(cfg_psel),
      .div_pulse(div_pulse), .mod_ctrl(mod_ctrl), .cfg_invalid(cfg_invalid)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int fix_b(input int b);
      return (b == 0) ? 1 : b;
   endfunction

   function automatic int fix_a(input int a, input int b);
      return (a > fix_b(b)) ? fix_b(b) : a;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // reference model: advances on the rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         k <= 0;
         act_a <= 0; act_b <= 1; act_p <= 8;
         pend_a <= 0; pend_b <= 1; pend_p <= 8; pend_inv <= 1'b0;
      end else begin
         if (cfg_load) begin
            pend_a   <= fix_a(int'(cfg_a), int'(cfg_b));
            pend_b   <= fix_b(int'(cfg_b));
            pend_p   <= 8 << cfg_psel;
            pend_inv <= (cfg_b == 0) || (int'(cfg_a) > int'(cfg_b));
         end
         if (k == act_b * act_p + act_a - 1) begin
            k <= 0;
            act_a <= pend_a; act_b <= pend_b; act_p <= pend_p;
         end else begin
            k <= k + 1;
         end
      end
   end

   // cycle-by-cycle comparison away from the rising edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(div_pulse == (k == act_b * act_p + act_a - 1), "R2 pulse", div_pulse,
             k == act_b * act_p + act_a - 1);
         chk(mod_ctrl == (k < act_a * (act_p + 1)), "R3 mod_ctrl", mod_ctrl,
             k < act_a * (act_p + 1));
         chk(cfg_invalid == pend_inv, "R8 cfg_invalid", cfg_invalid, pend_inv);
      end
   end

   task automatic do_load(input int a, input int b, input int s);
      @(negedge clk);
      cfg_a = 5'(a); cfg_b = 13'(b); cfg_psel = 2'(s); cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
   endtask

   task automatic wait_pulse();
      while (!div_pulse) @(negedge clk);
   endtask

   // called at a negedge where div_pulse is high; measures the next period
   task automatic measure(output int len, output int modc);
      len = 0; modc = 0;
      do begin
         @(negedge clk);
         len++;
         if (mod_ctrl) modc++;
      end while (!div_pulse);
   endtask

   task automatic run_cfg(input int a, input int b, input int s, input int exp_n,
                          input int exp_m, input string req);
      int len, modc;
      do_load(a, b, s);
      wait_pulse();
      measure(len, modc);
      chk(len == exp_n, {req, " period"}, len, exp_n);
      chk(modc == exp_m, {req, " P+1 cycles"}, modc, exp_m);
   endtask

   initial begin
      int len, modc;
      // R1: reset state
      repeat (4) @(negedge clk);
      chk(div_pulse == 1'b0, "R1 pulse in reset", div_pulse, 0);
      chk(mod_ctrl == 1'b0, "R1 mod in reset", mod_ctrl, 0);
      chk(cfg_invalid == 1'b0, "R1 flag in reset", cfg_invalid, 0);
      rst_n = 1'b1;
      wait_pulse();
      measure(len, modc);
      chk(len == 8, "R1 default period", len, 8);

      // R2 R3: basic ratio
      run_cfg(3, 5, 0, 43, 27, "R2");
      run_cfg(1, 2, 0, 17, 9, "R3");
      // R4: prescaler select codes
      run_cfg(2, 4, 1, 66, 34, "R4 P16");
      run_cfg(2, 4, 2, 130, 66, "R4 P32");
      run_cfg(2, 4, 3, 258, 130, "R4 P64");
      // R10: no swallow
      run_cfg(0, 6, 2, 192, 0, "R10");
      // A equal to B boundary
      run_cfg(31, 31, 3, 2015, 2015, "R3 A=B");

      // R6: A above B is clamped and flagged
      do_load(20, 3, 0);
      chk(cfg_invalid == 1'b1, "R6 flag", cfg_invalid, 1);
      wait_pulse();
      measure(len, modc);
      chk(len == 27, "R6 clamped period", len, 27);
      chk(modc == 27, "R6 all P+1", modc, 27);

      // R7: zero B
      do_load(5, 0, 0);
      chk(cfg_invalid == 1'b1, "R7 flag", cfg_invalid, 1);
      wait_pulse();
      measure(len, modc);
      chk(len == 9, "R7 period", len, 9);

      // R8: legal load clears the flag
      do_load(1, 3, 0);
      chk(cfg_invalid == 1'b0, "R8 flag cleared", cfg_invalid, 0);
      wait_pulse();
      measure(len, modc);
      chk(len == 25, "R8 period", len, 25);

      // R5: a load in mid-period leaves the running period alone
      wait_pulse();
      len = 0;
      do begin
         @(negedge clk);
         len++;
         if (len == 5) begin
            cfg_a = 5'd0; cfg_b = 13'd2; cfg_psel = 2'd1; cfg_load = 1'b1;
         end else begin
            cfg_load = 1'b0;
         end
      end while (!div_pulse);
      chk(len == 25, "R5 current period kept", len, 25);
      measure(len, modc);
      chk(len == 32, "R5 new period", len, 32);

      // R9: last of several loads wins
      do_load(4, 9, 0);
      do_load(2, 7, 0);
      do_load(1, 5, 1);
      wait_pulse();
      measure(len, modc);
      chk(len == 81, "R9 last load", len, 81);
      chk(modc == 17, "R9 P+1 cycles", modc, 17);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule